// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point numbers. Each number has a sign bit (bit 31), an 8-bit biased exponent (bits 30:23, bias 127) and a 23-bit fraction (bits 22:0) with an implicit leading one. A caller presents both operands together with a valid strobe. One clock later the packed product appears with its own valid strobe and an invalid-operation flag. The result register keeps its value until the next accepted operation.

Each operation first goes through a special-value stage that classifies both operands. An exponent field of 0 counts as zero, so subnormal inputs are flushed. An exponent field of 255 counts as infinity when the fraction is zero and as NaN when it is not. When neither operand is special, the datapath runs: it adds the biased exponents and removes one bias, multiplies the two 24-bit significands into a 48-bit product, normalises the product, rounds to nearest with ties to even, and then checks the exponent range. Subnormal results are never produced.

Top module: `fpmul_sp`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `result` is 0x00000000 and `invalid` is 0 until the first operation is accepted.
- R2: An operation accepted on a clock edge with `in_valid` high produces `out_valid` high after that edge and before the next one. An edge with `in_valid` low produces `out_valid` low, and `result` and `invalid` keep their values.
- R3: For every result that is not NaN, result bit 31 is the XOR of the two operand sign bits (bit 31).
- R4: An operand whose exponent field (bits 30:23) is 0 is treated as zero whatever its fraction. When the other operand is neither infinity nor NaN, the result is a zero with the XOR sign: fraction 0 and exponent 0.
- R5: If either operand has exponent field 255 and a nonzero fraction, the result is 0x7FC00000 and `invalid` is 0. This holds even when the other operand is zero.
- R6: A zero operand paired with an infinity (exponent 255, fraction 0) gives 0x7FC00000 and `invalid` 1. This holds in either order and for any signs.
- R7: An infinity times a nonzero, non-NaN operand gives an infinity (exponent 255, fraction 0) with the XOR sign.
- R8: For two normal operands, the result exponent is ea+eb-127. The 48-bit product of the 24-bit significands is shifted right by one, and the exponent raised by one, when product bit 47 is set.
- R9: The bits dropped below the 24 kept significand bits are rounded to nearest. An exact half rounds toward the even kept value.
- R10: A round-up that carries out of the 24-bit significand leaves fraction 0 and raises the exponent by one.
- R11: When the final biased exponent is 255 or more, the result is a signed infinity. This includes the case where R10 pushes the exponent to 255.
- R12: When the final biased exponent is 0 or less, the result is a signed zero.
- R13: `invalid` is 1 only for the case in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | `result` and `invalid` hold a new product |
| result | output | 32 | Packed product |
| invalid | output | 1 | Zero multiplied by infinity |

## Verification
Round-to-nearest and the exponent range check can act in the same cycle. A significand of all ones plus a guard-and-sticky round-up carries into the exponent, and if that exponent was already 254 the carry alone turns the result into infinity. The bench provokes this with 0x7F7FFFFE times 0x3F800001, and it runs the same significand pair at lower exponents to show the carry without overflow. A scoreboard model judges each case by integer division with remainder against the half point, which is a different method from the RTL's guard/sticky decode.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Outcome picked by the special-value stage, in priority order
  typedef enum logic [2:0] {
    KIND_NUM,
    KIND_ZERO,
    KIND_INF,
    KIND_NAN,
    KIND_INVALID
  } fpm_kind_e;

  // Round-to-nearest-even increment decision
  function automatic logic rne_inc(input logic lsb, input logic guard, input logic sticky);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] word,
  output logic           sign,
  output logic [EW-1:0]  exp_f,
  output logic [FW:0]    sig,
  output logic           is_zero,
  output logic           is_inf,
  output logic           is_nan
);
  logic [FW-1:0] frac;
  logic          exp_max;

  assign sign    = word[EW+FW];
  assign exp_f   = word[EW+FW-1:FW];
  assign frac    = word[FW-1:0];
  assign exp_max = &exp_f;
  // exponent field 0 means zero: subnormals are flushed
  assign is_zero = (exp_f == '0);
  assign is_inf  = exp_max && (frac == '0);
  assign is_nan  = exp_max && (frac != '0);
  assign sig     = is_zero ? '0 : {1'b1, frac};
endmodule

// File: rtl/fpm_special.sv
module fpm_special
  import fpm_pkg::*;
(
  input  logic      a_zero,
  input  logic      a_inf,
  input  logic      a_nan,
  input  logic      b_zero,
  input  logic      b_inf,
  input  logic      b_nan,
  output fpm_kind_e kind
);
  always_comb begin
    if (a_nan || b_nan)                          kind = KIND_NAN;
    else if ((a_zero && b_inf) || (a_inf && b_zero)) kind = KIND_INVALID;
    else if (a_inf || b_inf)                     kind = KIND_INF;
    else if (a_zero || b_zero)                   kind = KIND_ZERO;
    else                                         kind = KIND_NUM;
  end
endmodule

// File: rtl/fpm_core.sv
module fpm_core
  import fpm_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW-1:0] exp_a,
  input  logic [EW-1:0] exp_b,
  input  logic [FW:0]   sig_a,
  input  logic [FW:0]   sig_b,
  output logic [EW-1:0] exp_out,
  output logic [FW-1:0] frac_out,
  output logic          ovf,
  output logic          unf,
  output logic          rnd_carry
);
  localparam int SW   = FW + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = EW + 2;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [PW-1:0] prod;
  logic          top;
  logic [SW-1:0] keep;
  logic          guard;
  logic          sticky;
  logic          up;
  logic [SW:0]   rounded;
  logic [XW-1:0] e_sum;
  logic [XW-1:0] e_fin;

  assign prod = PW'(sig_a) * PW'(sig_b);
  assign top  = prod[PW-1];

  // normalise: product in [2,4) keeps the upper window
  always_comb begin
    if (top) begin
      keep   = prod[PW-1 -: SW];
      guard  = prod[PW-1-SW];
      sticky = |prod[PW-2-SW:0];
    end else begin
      keep   = prod[PW-2 -: SW];
      guard  = prod[PW-2-SW];
      sticky = |prod[PW-3-SW:0];
    end
  end

  assign up        = rne_inc(keep[0], guard, sticky);
  assign rounded   = {1'b0, keep} + (SW+1)'(up);
  assign rnd_carry = rounded[SW];

  assign e_sum = XW'(exp_a) + XW'(exp_b) - XW'(BIAS) + XW'(top);
  assign e_fin = e_sum + XW'(rnd_carry);

  assign ovf      = !e_fin[XW-1] && (e_fin[XW-2:0] >= {1'b0, {EW{1'b1}}});
  assign unf      = e_fin[XW-1] || (e_fin == '0);
  assign exp_out  = e_fin[EW-1:0];
  assign frac_out = rounded[FW-1:0];

  // a carry out of rounding is only possible from an all-ones window
  always_comb begin
    if (rnd_carry) assert_carry_needs_ones_R10: assert (&keep);
  end
endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
  import fpm_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [EW+FW:0]   op_a,
  input  logic [EW+FW:0]   op_b,
  output logic             out_valid,
  output logic [EW+FW:0]   result,
  output logic             invalid
);
  localparam int WW = EW + FW + 1;
  localparam logic [WW-2:0] QNAN_BODY = {{EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [WW-2:0] INF_BODY  = {{EW{1'b1}}, {FW{1'b0}}};

  logic [WW-1:0] ops      [2];
  logic          sgn      [2];
  logic [EW-1:0] ex       [2];
  logic [FW:0]   sg       [2];
  logic          zr       [2];
  logic          nf       [2];
  logic          nn       [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpm_unpack #(.EW(EW), .FW(FW)) u_unpack (
      .word(ops[i]), .sign(sgn[i]), .exp_f(ex[i]), .sig(sg[i]),
      .is_zero(zr[i]), .is_inf(nf[i]), .is_nan(nn[i])
    );
  end

  fpm_kind_e     kind;
  logic [EW-1:0] core_exp;
  logic [FW-1:0] core_frac;
  logic          core_ovf;
  logic          core_unf;
  logic          core_carry;
  logic          res_sign;
  logic          nan_event;
  logic [WW-1:0] next_res;

  fpm_special u_special (
    .a_zero(zr[0]), .a_inf(nf[0]), .a_nan(nn[0]),
    .b_zero(zr[1]), .b_inf(nf[1]), .b_nan(nn[1]),
    .kind(kind)
  );

  fpm_core #(.EW(EW), .FW(FW)) u_core (
    .exp_a(ex[0]), .exp_b(ex[1]), .sig_a(sg[0]), .sig_b(sg[1]),
    .exp_out(core_exp), .frac_out(core_frac),
    .ovf(core_ovf), .unf(core_unf), .rnd_carry(core_carry)
  );

  assign res_sign  = sgn[0] ^ sgn[1];
  assign nan_event = (kind == KIND_NAN) || (kind == KIND_INVALID);

  always_comb begin
    unique case (kind)
      KIND_NAN, KIND_INVALID: next_res = {1'b0, QNAN_BODY};
      KIND_INF:               next_res = {res_sign, INF_BODY};
      KIND_ZERO:              next_res = {res_sign, {(WW-1){1'b0}}};
      default: begin
        if (core_ovf)      next_res = {res_sign, INF_BODY};
        else if (core_unf) next_res = {res_sign, {(WW-1){1'b0}}};
        else               next_res = {res_sign, core_exp, core_frac};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_res;
        invalid <= (kind == KIND_INVALID);
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));
  assert_invalid_canonical_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid) |-> (result == {1'b0, QNAN_BODY}));
  assert_sign_xor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_event) |=> (result[WW-1] == $past(op_a[WW-1] ^ op_b[WW-1])));
  assert_overflow_inf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == KIND_NUM && core_ovf) |=> (result[WW-2:0] == INF_BODY));
endmodule

// File: tb/fpmul_sp_tb.sv
module fpmul_sp_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] QNAN = 32'h7FC00000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [32:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpmul_sp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  // Reference: integer quotient/remainder rounding; returns {invalid, result}
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    int          ea = int'(a[30:23]);
    int          eb = int'(b[30:23]);
    bit          s  = a[31] ^ b[31];
    bit          za = (ea == 0), zb = (eb == 0);
    bit          ia = (ea == 255) && (a[22:0] == 0);
    bit          ib = (eb == 255) && (b[22:0] == 0);
    bit          na = (ea == 255) && (a[22:0] != 0);
    bit          nb = (eb == 255) && (b[22:0] != 0);
    longint unsigned p, q, r, h;
    int          e, sh;
    if (na || nb) return {1'b0, QNAN};
    if ((za && ib) || (ia && zb)) return {1'b1, QNAN};
    if (ia || ib) return {1'b0, s, 8'hFF, 23'd0};
    if (za || zb) return {1'b0, s, 31'd0};
    p  = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e  = ea + eb - 127;
    sh = 23;
    if (p >= (64'd1 << 47)) begin sh = 24; e = e + 1; end
    q = p >> sh;
    r = p - (q << sh);
    h = 64'd1 << (sh - 1);
    if (r > h || (r == h && q[0])) q = q + 1;
    if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
    if (e >= 255) return {1'b0, s, 8'hFF, 23'd0};
    if (e <= 0)   return {1'b0, s, 31'd0};
    return {1'b0, s, 8'(e), q[22:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual inv=%0b res=%08h expected inv=%0b res=%08h",
               tag, act[32], act[31:0], expv[32], expv[31:0]);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    exp_q.push_back(model(a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected items when results emerge
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 spurious out_valid", {invalid, result}, 33'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check({invalid, result} === e, t, {invalid, result}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && result === 32'd0 && invalid === 1'b0, "R1 during reset",
          {invalid, result}, 33'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0 && result === 32'd0 && invalid === 1'b0, "R1 after reset",
          {invalid, result}, 33'd0);

    // R8 normal products, with and without the normalising shift
    drive(32'h40400000, 32'h40000000, "R8 3*2");
    drive(32'h3FC00000, 32'h3FC00000, "R8 1.5*1.5 shift");
    drive(32'h42F60000, 32'h3DCCCCCD, "R8 123*0.1");
    // R3 signs
    drive(32'hC0400000, 32'h40000000, "R3 neg*pos");
    drive(32'hC0400000, 32'hC0A00000, "R3 neg*neg");
    // R4 zeros and flushed subnormals
    drive(32'h80000000, 32'h41200000, "R4 -0*10");
    drive(32'h00000001, 32'hBF800000, "R4 subnormal*-1");
    // R5 NaN priority, R13 invalid low
    drive(32'h7F800001, 32'h00000000, "R5 NaN*0 R13");
    drive(32'hFFC00000, 32'h7F800000, "R5 NaN*inf");
    // R6 zero times infinity, both orders and signs
    drive(32'h00000000, 32'h7F800000, "R6 0*inf");
    drive(32'hFF800000, 32'h80000000, "R6 -inf*-0");
    drive(32'h80400000, 32'h7F800000, "R6 flushed*inf");
    // R7 infinity
    drive(32'h7F800000, 32'hC0000000, "R7 inf*-2");
    drive(32'hFF800000, 32'hFF800000, "R7 -inf*-inf");
    // R9 exact halves: odd keep rounds up, even keep stays
    drive(32'h3F800001, 32'h3FC00000, "R9 tie odd");
    drive(32'h3F800003, 32'h3FC00000, "R9 tie even");
    // R10 rounding carry, R11 carry into overflow
    drive(32'h3F7FFFFE, 32'h3F800001, "R10 carry");
    drive(32'h7F7FFFFE, 32'h3F000001, "R10 carry high");
    drive(32'h7F7FFFFE, 32'h3F800001, "R11 carry overflow");
    drive(32'h7F000000, 32'hC0000000, "R11 overflow");
    // R12 underflow
    drive(32'h00800000, 32'h3F000000, "R12 underflow");
    drive(32'h80800000, 32'h3F7FFFFF, "R12 neg underflow");
    idle(4);
    // R2 hold while idle
    check(out_valid === 1'b0 && {invalid, result} === last_exp, "R2 hold",
          {invalid, result}, last_exp);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (k % 4 != 0) begin
        a[30:23] = 8'(64 + ($urandom % 128));
        b[30:23] = 8'(64 + ($urandom % 128));
      end
      drive(a, b, "R8 random");
      if (k % 37 == 0) idle(2);
    end
    idle(4);
    check(exp_q.size() == 0, "R2 all results seen", 33'(exp_q.size()), 33'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule